// File: doc/BRIEF.md
# Partial Configuration Image Loader

This block moves a stored partial configuration image to a 32-bit configuration port, or copies it into a local 32-bit buffer RAM. A single start pulse with an operation code picks one of three transfers. External flash can go to the port or to the buffer, and the buffer can go to the port. The only operand is the image's start address. The image begins with one 32-bit header word that holds the payload length in bytes, not counting the header. From that length the loader works out the address just past the last payload unit and stops there on its own.

Flash is read through a simple 16-bit port with a request/valid handshake and a fixed latency. The loader joins two half-words into each 32-bit word, high half first, so every flash word costs two full read latencies (about 26 cycles). The buffer has a one-cycle read latency, and the loader streams it at one word per clock. A copy into the buffer always lands just above a reserved low region (2800 bytes, word 700 onward). The header is copied as well, so the buffer copy can later be sent with the buffer-to-port mode.

Every transfer to the port ends with a desynchronise command word. The operation only finishes when the port acknowledges that command. The controller is one state machine: ST_IDLE (wait for start), ST_HDR (issue header read), ST_HDR_WAIT (capture the length), ST_CHECK (compute the end, check the fit, write the header on a copy), ST_BODY (move the payload), ST_DESYNC (send the command), ST_ACK_WAIT (wait for the acknowledge) and ST_FIN (pulse done). Its transitions are:
- ST_IDLE goes to ST_HDR on an accepted start.
- ST_HDR goes to ST_HDR_WAIT.
- ST_HDR_WAIT goes to ST_CHECK when the header arrives.
- ST_CHECK goes to ST_FIN on an oversize copy, and to ST_BODY otherwise.
- ST_BODY goes to ST_DESYNC (port modes) or ST_FIN (copy) once all payload words are delivered.
- ST_DESYNC goes to ST_ACK_WAIT.
- ST_ACK_WAIT goes to ST_FIN on acknowledge.
- ST_FIN goes to ST_IDLE.

Top module: `lb_bitstream_loader`

## Requirements
- R1: With start high in the idle state, op_sel 3'b101 selects flash to port, 3'b110 selects flash to buffer and 3'b111 selects buffer to port. Any other code is ignored: busy stays low and done does not pulse.
- R2: The first 32-bit word of an image is its payload length in bytes, excluding the header, and is assumed a multiple of 4. The payload is length/4 words. A flash image spans 2 + length/2 half-words from the start address. A buffer image spans 1 + length/4 words.
- R3: Flash words are built from two single-cycle read requests: half-word address a gives bits 31:16 and address a+1 gives bits 15:0. A new request is only issued after the previous read has returned.
- R4: In flash-to-port mode, every payload word (not the header) appears in address order on cfg_data with cfg_en high for one cycle.
- R5: In buffer-to-port mode, the header is at the start word address and the payload follows it. Payload words reach the port on consecutive clock cycles.
- R6: Each port-mode transfer ends with exactly one cfg_en cycle carrying 32'h0000000D. Done is raised only after cfg_ack is seen following that word.
- R7: A flash-to-buffer copy writes the header at word 700 (2800 reserved bytes) and the payload at the words after it. No word below 700 is ever written.
- R8: If a copy's payload exceeds BUF_WORDS-701 words, nothing is written, and done pulses together with error.
- R9: Done is a one-cycle pulse, once per accepted operation. Error is only ever high together with done.
- R10: A start pulse while busy is ignored and does not alter the running transfer.
- R11: After reset, busy, done, error, cfg_en, flash_req, buf_rd_en and buf_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled in idle |
| op_sel | input | 3 | Transfer select code |
| img_addr | input | FLASH_AW | Image start: half-word address for flash, word address for buffer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Oversize copy abort, with done |
| flash_req | output | 1 | Flash half-word read request |
| flash_addr | output | FLASH_AW | Flash half-word address |
| flash_valid | input | 1 | Flash read data valid |
| flash_data | input | 16 | Flash read data |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | BUF_AW | Buffer read word address |
| buf_rd_data | input | 32 | Buffer read data, one cycle after enable |
| buf_wr_en | output | 1 | Buffer write enable |
| buf_wr_addr | output | BUF_AW | Buffer write word address |
| buf_wr_data | output | 32 | Buffer write data |
| cfg_en | output | 1 | Configuration port word strobe |
| cfg_data | output | 32 | Configuration port word |
| cfg_ack | input | 1 | Port acknowledge of the desynchronise word |

## Verification
The assertions assume a few things about the environment. Flash returns exactly one valid per request, and never in the request cycle itself. Buffer data follows a read one cycle later. cfg_ack arrives only after a desynchronise word has been sent. Image lengths are multiples of four bytes. The bench's flash model returns each read after a fixed 12-cycle wait. Its buffer model is a registered RAM. Its port model raises a single acknowledge six cycles after it sees the desynchronise word. Every test image is built with a length that divides by four.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam logic [2:0] OP_FLASH_TO_PORT = 3'b101;
    localparam logic [2:0] OP_FLASH_TO_BUF  = 3'b110;
    localparam logic [2:0] OP_BUF_TO_PORT   = 3'b111;
    localparam logic [31:0] DESYNC_WORD     = 32'h0000000D;

    typedef enum logic [1:0] {
        MODE_F2P,
        MODE_F2B,
        MODE_B2P
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_WAIT,
        ST_CHECK,
        ST_BODY,
        ST_DESYNC,
        ST_ACK_WAIT,
        ST_FIN
    } ld_state_e;

    typedef enum logic [2:0] {
        FW_IDLE,
        FW_REQ_HI,
        FW_WAIT_HI,
        FW_REQ_LO,
        FW_WAIT_LO
    } fw_state_e;
endpackage

// File: rtl/lb_flash_word.sv
module lb_flash_word
    import lb_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch,
    input  logic [AW-1:0] addr,
    output logic          fw_busy,
    output logic          flash_req,
    output logic [AW-1:0] flash_addr,
    input  logic          flash_valid,
    input  logic [15:0]   flash_data,
    output logic          word_valid,
    output logic [31:0]   word
);
    fw_state_e     st_q, st_d;
    logic [AW-1:0] addr_q;
    logic [15:0]   hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FW_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FW_IDLE:    if (fetch) st_d = FW_REQ_HI;
            FW_REQ_HI:  st_d = FW_WAIT_HI;
            FW_WAIT_HI: if (flash_valid) st_d = FW_REQ_LO;
            FW_REQ_LO:  st_d = FW_WAIT_LO;
            FW_WAIT_LO: if (flash_valid) st_d = FW_IDLE;
            default:    st_d = FW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            hi_q   <= '0;
        end else begin
            if (st_q == FW_IDLE && fetch)      addr_q <= addr;
            if (st_q == FW_WAIT_HI && flash_valid) hi_q <= flash_data;
        end
    end

    always_comb begin
        fw_busy    = (st_q != FW_IDLE);
        flash_req  = (st_q == FW_REQ_HI) || (st_q == FW_REQ_LO);
        flash_addr = (st_q == FW_REQ_LO) ? addr_q + AW'(1) : addr_q;
        word_valid = (st_q == FW_WAIT_LO) && flash_valid;
        word       = {hi_q, flash_data};
    end
endmodule

// File: rtl/lb_size_calc.sv
module lb_size_calc #(
    parameter int PTR_W = 24,
    parameter int CNT_W = 30,
    parameter int CAP   = 7363
) (
    input  logic             from_flash,
    input  logic [PTR_W-1:0] base,
    input  logic [31:0]      size_bytes,
    output logic [PTR_W-1:0] end_ptr,
    output logic [CNT_W-1:0] words,
    output logic             fits
);
    logic [PTR_W-1:0] span;

    always_comb begin
        words = size_bytes[31:2];
        if (from_flash) span = PTR_W'(size_bytes[31:1]) + PTR_W'(2);
        else            span = PTR_W'(size_bytes[31:2]) + PTR_W'(1);
        end_ptr = base + span;
        fits    = ({2'b00, words} <= (CNT_W+2)'(CAP));
    end
endmodule

// File: rtl/lb_bitstream_loader.sv
module lb_bitstream_loader
    import lb_pkg::*;
#(
    parameter int FLASH_AW  = 24,
    parameter int BUF_AW    = 13,
    parameter int BUF_WORDS = 8064,
    parameter int RSV_BYTES = 2800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          op_sel,
    input  logic [FLASH_AW-1:0] img_addr,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic                flash_req,
    output logic [FLASH_AW-1:0] flash_addr,
    input  logic                flash_valid,
    input  logic [15:0]         flash_data,
    output logic                buf_rd_en,
    output logic [BUF_AW-1:0]   buf_rd_addr,
    input  logic [31:0]         buf_rd_data,
    output logic                buf_wr_en,
    output logic [BUF_AW-1:0]   buf_wr_addr,
    output logic [31:0]         buf_wr_data,
    output logic                cfg_en,
    output logic [31:0]         cfg_data,
    input  logic                cfg_ack
);
    localparam int PTR_W     = FLASH_AW;
    localparam int CNT_W     = 30;
    localparam int RSV_WORDS = RSV_BYTES / 4;
    localparam int CAP_WORDS = BUF_WORDS - RSV_WORDS - 1;

    ld_state_e        st_q, st_d;
    mode_e            mode_q;
    logic [PTR_W-1:0] base_q, ptr_q, end_q;
    logic [CNT_W-1:0] words_q, sunk_q;
    logic [31:0]      size_q;
    logic [BUF_AW-1:0] wr_ptr_q;
    logic             err_q, rd_q;

    logic             op_ok;
    mode_e            op_mode;
    logic             from_flash, to_port;
    logic             fw_fetch, fw_busy, fw_valid;
    logic [31:0]      fw_word;
    logic             src_valid;
    logic [31:0]      src_word;
    logic [PTR_W-1:0] sc_end;
    logic [CNT_W-1:0] sc_words;
    logic             sc_fits;
    logic             issue_ok;

    lb_flash_word #(.AW(FLASH_AW)) u_fw (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch      (fw_fetch),
        .addr       (ptr_q),
        .fw_busy    (fw_busy),
        .flash_req  (flash_req),
        .flash_addr (flash_addr),
        .flash_valid(flash_valid),
        .flash_data (flash_data),
        .word_valid (fw_valid),
        .word       (fw_word)
    );

    lb_size_calc #(.PTR_W(PTR_W), .CNT_W(CNT_W), .CAP(CAP_WORDS)) u_sc (
        .from_flash (from_flash),
        .base       (base_q),
        .size_bytes (size_q),
        .end_ptr    (sc_end),
        .words      (sc_words),
        .fits       (sc_fits)
    );

    always_comb begin
        op_ok   = 1'b1;
        op_mode = MODE_F2P;
        unique case (op_sel)
            OP_FLASH_TO_PORT: op_mode = MODE_F2P;
            OP_FLASH_TO_BUF:  op_mode = MODE_F2B;
            OP_BUF_TO_PORT:   op_mode = MODE_B2P;
            default:          op_ok   = 1'b0;
        endcase
    end

    assign from_flash = (mode_q != MODE_B2P);
    assign to_port    = (mode_q != MODE_F2B);
    assign src_valid  = from_flash ? fw_valid : rd_q;
    assign src_word   = from_flash ? fw_word  : buf_rd_data;
    assign issue_ok   = (ptr_q != end_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start && op_ok) st_d = ST_HDR;
            ST_HDR:      st_d = ST_HDR_WAIT;
            ST_HDR_WAIT: if (src_valid) st_d = ST_CHECK;
            ST_CHECK:    st_d = (mode_q == MODE_F2B && !sc_fits) ? ST_FIN : ST_BODY;
            ST_BODY:     if (sunk_q == words_q) st_d = to_port ? ST_DESYNC : ST_FIN;
            ST_DESYNC:   st_d = ST_ACK_WAIT;
            ST_ACK_WAIT: if (cfg_ack) st_d = ST_FIN;
            ST_FIN:      st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (st_q != ST_IDLE);
        done        = (st_q == ST_FIN);
        error       = (st_q == ST_FIN) && err_q;
        fw_fetch    = 1'b0;
        buf_rd_en   = 1'b0;
        buf_rd_addr = ptr_q[BUF_AW-1:0];
        buf_wr_en   = 1'b0;
        buf_wr_addr = wr_ptr_q;
        buf_wr_data = src_word;
        cfg_en      = 1'b0;
        cfg_data    = src_word;
        unique case (st_q)
            ST_HDR: begin
                if (from_flash) fw_fetch  = 1'b1;
                else            buf_rd_en = 1'b1;
            end
            ST_CHECK: begin
                if (mode_q == MODE_F2B && sc_fits) begin
                    buf_wr_en   = 1'b1;
                    buf_wr_data = size_q;
                end
            end
            ST_BODY: begin
                if (from_flash) fw_fetch  = issue_ok && !fw_busy;
                else            buf_rd_en = issue_ok;
                if (src_valid) begin
                    if (to_port) cfg_en    = 1'b1;
                    else         buf_wr_en = 1'b1;
                end
            end
            ST_DESYNC: begin
                cfg_en   = 1'b1;
                cfg_data = DESYNC_WORD;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_F2P;
            base_q   <= '0;
            ptr_q    <= '0;
            end_q    <= '0;
            words_q  <= '0;
            sunk_q   <= '0;
            size_q   <= '0;
            wr_ptr_q <= BUF_AW'(RSV_WORDS);
            err_q    <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            rd_q <= buf_rd_en;
            if (st_q == ST_IDLE && start && op_ok) begin
                mode_q   <= op_mode;
                base_q   <= img_addr;
                ptr_q    <= img_addr;
                sunk_q   <= '0;
                wr_ptr_q <= BUF_AW'(RSV_WORDS);
                err_q    <= 1'b0;
            end
            if (fw_fetch)  ptr_q <= ptr_q + PTR_W'(2);
            if (buf_rd_en) ptr_q <= ptr_q + PTR_W'(1);
            if (st_q == ST_HDR_WAIT && src_valid) size_q <= src_word;
            if (st_q == ST_CHECK) begin
                end_q   <= sc_end;
                words_q <= sc_words;
                if (mode_q == MODE_F2B && !sc_fits) err_q <= 1'b1;
            end
            if (st_q == ST_BODY && src_valid) sunk_q <= sunk_q + CNT_W'(1);
            if (buf_wr_en) wr_ptr_q <= wr_ptr_q + BUF_AW'(1);
        end
    end
endmodule

// File: rtl/lb_bitstream_loader_chk.sv
module lb_bitstream_loader_chk #(
    parameter int BUF_AW    = 13,
    parameter int RSV_BYTES = 2800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              flash_req,
    input logic              buf_rd_en,
    input logic              buf_wr_en,
    input logic [BUF_AW-1:0] buf_wr_addr,
    input logic              cfg_en
);
    localparam int RSV_WORDS = RSV_BYTES / 4;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_error_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_no_reserved_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (32'(buf_wr_addr) >= RSV_WORDS));
    assert_flash_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |=> !flash_req);
    assert_activity_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en || buf_wr_en || flash_req || buf_rd_en) |-> busy);
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_sink_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && buf_wr_en));
endmodule

bind lb_bitstream_loader lb_bitstream_loader_chk #(.BUF_AW(BUF_AW), .RSV_BYTES(RSV_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .flash_req  (flash_req),
    .buf_rd_en  (buf_rd_en),
    .buf_wr_en  (buf_wr_en),
    .buf_wr_addr(buf_wr_addr),
    .cfg_en     (cfg_en)
);

// File: tb/tb_lb_bitstream_loader.sv
module tb_lb_bitstream_loader;
    localparam int CLK_PERIOD = 10;
    localparam int FAW = 24;
    localparam int BAW = 13;
    localparam int FLAT = 13;
    localparam logic [31:0] DSY = 32'h0000000D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op_sel = 3'b000;
    logic [FAW-1:0] img_addr = '0;
    logic busy, done, error, flash_req, flash_valid, buf_rd_en, buf_wr_en, cfg_en;
    logic cfg_ack;
    logic [FAW-1:0] flash_addr;
    logic [15:0] flash_data;
    logic [BAW-1:0] buf_rd_addr, buf_wr_addr;
    logic [31:0] buf_rd_data, buf_wr_data, cfg_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    lb_bitstream_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .img_addr(img_addr),
        .busy(busy), .done(done), .error(error),
        .flash_req(flash_req), .flash_addr(flash_addr), .flash_valid(flash_valid), .flash_data(flash_data),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .cfg_en(cfg_en), .cfg_data(cfg_data), .cfg_ack(cfg_ack)
    );

    // flash model
    logic [15:0] fmem [0:1023];
    logic [9:0]  f_a;
    int          f_cnt;
    assign flash_valid = (f_cnt == 1);
    assign flash_data  = fmem[f_a];
    always @(posedge clk) begin
        if (flash_req) begin f_cnt <= FLAT; f_a <= flash_addr[9:0]; end
        else if (f_cnt != 0) f_cnt <= f_cnt - 1;
    end

    // buffer model
    logic [31:0] bmem [0:8191];
    logic        pre_we = 1'b0;
    logic [BAW-1:0] pre_a = '0;
    logic [31:0] pre_d = '0;
    always @(posedge clk) begin
        if (pre_we) bmem[pre_a] <= pre_d;
        if (buf_wr_en) bmem[buf_wr_addr] <= buf_wr_data;
        if (buf_rd_en) buf_rd_data <= bmem[buf_rd_addr];
    end

    // port model and monitors
    int ack_cnt;
    assign cfg_ack = (ack_cnt == 1);
    int cyc, cfg_n, wr_n, done_n, err_n, desync_cyc, done_cyc;
    logic [31:0] cfg_log [0:63];
    int cfg_cyc [0:63];
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cfg_en && cfg_data == DSY) begin ack_cnt <= 6; desync_cyc <= cyc; end
        else if (ack_cnt != 0) ack_cnt <= ack_cnt - 1;
        if (cfg_en) begin
            if (cfg_n < 64) begin cfg_log[cfg_n] <= cfg_data; cfg_cyc[cfg_n] <= cyc; end
            cfg_n <= cfg_n + 1;
        end
        if (buf_wr_en) wr_n <= wr_n + 1;
        if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
        if (error) err_n <= err_n + 1;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go(input logic [2:0] op, input logic [FAW-1:0] a);
        @(negedge clk);
        start = 1'b1; op_sel = op; img_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n0 = done_n;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done_n != n0) return;
        end
        n_chk++; n_bad++;
        $display("FAIL %s actual=timeout expected=done", req);
    endtask

    task automatic preload(input logic [BAW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    function automatic logic [31:0] fword(input int a);
        return {fmem[a], fmem[a+1]};
    endfunction

    task automatic t_reset;
        check("R11 busy", 32'(busy), 0);
        check("R11 done", 32'(done), 0);
        check("R11 error", 32'(error), 0);
        check("R11 outputs", 32'({cfg_en, flash_req, buf_rd_en, buf_wr_en}), 0);
    endtask

    task automatic t_flash_to_port;
        int c0 = cfg_n, d0 = done_n;
        go(3'b101, 100);
        wait_done("R4 flash to port");
        check("R4 word count (4 payload + desync)", 32'(cfg_n - c0), 5);
        for (int k = 0; k < 4; k++) check("R3 R4 payload word", cfg_log[c0+k], fword(102 + 2*k));
        check("R6 last word is desync", cfg_log[c0+4], DSY);
        check("R6 done waits for ack", 32'(done_cyc > desync_cyc + 5), 1);
        check("R9 one done", 32'(done_n - d0), 1);
        check("R2 flash word spacing", 32'(cfg_cyc[c0+1] - cfg_cyc[c0] >= 2*FLAT - 2), 1);
    endtask

    task automatic t_flash_to_buf;
        int w0 = wr_n, c0 = cfg_n;
        go(3'b110, 200);
        wait_done("R7 copy");
        @(negedge clk);
        check("R7 write count", 32'(wr_n - w0), 4);
        check("R7 header at 700", bmem[700], 32'd12);
        for (int k = 0; k < 3; k++) check("R7 payload in buffer", bmem[701+k], fword(202 + 2*k));
        check("R7 no port traffic", 32'(cfg_n - c0), 0);
        check("R9 no error", 32'(error), 0);
    endtask

    task automatic t_buf_to_port;
        int c0 = cfg_n;
        go(3'b111, 700);
        wait_done("R5 buffer to port");
        check("R5 word count", 32'(cfg_n - c0), 4);
        for (int k = 0; k < 3; k++) check("R5 payload word", cfg_log[c0+k], bmem[701+k]);
        check("R5 back to back 1", 32'(cfg_cyc[c0+1] - cfg_cyc[c0]), 1);
        check("R5 back to back 2", 32'(cfg_cyc[c0+2] - cfg_cyc[c0+1]), 1);
        check("R6 desync", cfg_log[c0+3], DSY);
    endtask

    task automatic t_oversize;
        int w0 = wr_n, e0 = err_n;
        preload(700, 32'hA5A5A5A5);
        go(3'b110, 300);
        wait_done("R8 oversize");
        @(negedge clk);
        check("R8 no writes", 32'(wr_n - w0), 0);
        check("R8 error pulsed", 32'(err_n - e0), 1);
        check("R8 buffer untouched", bmem[700], 32'hA5A5A5A5);
    endtask

    task automatic t_zero;
        int c0 = cfg_n;
        preload(5, 32'd0);
        go(3'b111, 5);
        wait_done("R2 zero length");
        check("R2 zero length sends desync only", 32'(cfg_n - c0), 1);
        check("R6 desync value", cfg_log[c0], DSY);
    endtask

    task automatic t_bad_op;
        int d0 = done_n;
        go(3'b011, 100);
        check("R1 bad op not busy", 32'(busy), 0);
        repeat (4) @(negedge clk);
        check("R1 bad op no done", 32'(done_n - d0), 0);
    endtask

    task automatic t_start_busy;
        int c0 = cfg_n, d0 = done_n;
        go(3'b101, 100);
        repeat (20) @(negedge clk);
        go(3'b111, 5);
        wait_done("R10 busy start");
        repeat (10) @(negedge clk);
        check("R10 single done", 32'(done_n - d0), 1);
        check("R10 stream length", 32'(cfg_n - c0), 5);
        check("R10 stream word", cfg_log[c0+3], fword(108));
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        cyc = 0; cfg_n = 0; wr_n = 0; done_n = 0; err_n = 0;
        desync_cyc = 0; done_cyc = 0; ack_cnt = 0; f_cnt = 0; f_a = '0;
        for (int i = 0; i < 1024; i++) fmem[i] = 16'(i * 7 + 3);
        fmem[100] = 16'h0000; fmem[101] = 16'd16;
        fmem[200] = 16'h0000; fmem[201] = 16'd12;
        fmem[300] = 16'h0000; fmem[301] = 16'h9C40;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_flash_to_port();
        t_flash_to_buf();
        t_buf_to_port();
        t_oversize();
        t_zero();
        t_bad_op();
        t_start_busy();
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end
endmodule